// File: doc/BRIEF.md
# Motion Wake-up and Sleep Engine

This block watches a stream of signed three-axis acceleration samples. Each sample comes with a one-cycle valid strobe at the engine rate. From that stream it decides when the device has moved for long enough to wake, and when it has stayed still for long enough to return to sleep. Motion is judged relative to the previous sample. For each axis, the signed change since the last valid sample is compared against an unsigned threshold. The threshold uses the same count scale as the samples: at 64 counts per g, half a g is programmed as 32.

Two debounce counters run in opposite senses. The wake counter counts consecutive moving samples while the device is asleep. The sleep counter counts consecutive still samples while the device is awake. Either counter restarts from zero as soon as its condition stops holding.

A wake sets the awake status, a latched wake flag and latched direction cause bits. A return to sleep clears the awake status and sets a latched sleep flag. The interrupt output follows the flags. A release strobe clears the flags and the cause bits. A force-sleep strobe puts the engine back to sleep at once. When the return-to-sleep engine is disabled, this strobe is the only way to make the engine able to wake again.

Top module: `motion_wake_engine`

## Requirements
- R1: After reset, awake, wake_flag, sleep_flag, cause and irq are all zero.
- R2: Motion on an axis is measured as the current valid sample minus the previous valid sample on that axis. The first valid sample after reset counts as a change of zero.
- R3: A direction is moving when the change exceeds the threshold strictly. For positive, the change must be greater than the threshold. For negative, the negated change must be greater than the threshold. A change equal to the threshold is not motion.
- R4: While asleep with wake_en high, the engine wakes when the number of consecutive valid samples having an enabled moving direction reaches wake_count (a value of 0 acts as 1). On the clock edge of the firing sample, awake and wake_flag go to 1.
- R5: A valid sample that does not qualify resets the counter in progress to zero. Cycles without smp_valid leave both counters unchanged.
- R6: dir_enable bit order is [0] +X, [1] -X, [2] +Y, [3] -Y, [4] +Z, [5] -Z. A disabled direction neither advances the wake counter nor appears in cause.
- R7: On a wake, cause ORs in the enabled moving directions of the firing sample, using the R6 encoding.
- R8: While awake with sleep_en high, sleep_count consecutive valid samples in which every axis has |change| <= sleep_thresh clear awake and set sleep_flag (0 acts as 1). Any sample exceeding the threshold resets the count.
- R9: A wake is only detected while asleep, and a return to sleep only while awake. With sleep_en low, the engine stays awake and wake_flag is not set again.
- R10: force_sleep clears awake on the next edge and restarts both counters. It leaves the flags unchanged and overrides a sample arriving in the same cycle.
- R11: release_flags clears wake_flag, sleep_flag and cause. An event firing in the same cycle still sets its flag.
- R12: irq is high exactly while wake_flag or sleep_flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_x | input | SMP_W | Signed X sample |
| smp_y | input | SMP_W | Signed Y sample |
| smp_z | input | SMP_W | Signed Z sample |
| wake_thresh | input | THR_W | Wake motion threshold, unsigned counts |
| sleep_thresh | input | THR_W | Sleep stillness threshold, unsigned counts |
| wake_count | input | CNT_W | Consecutive moving samples needed to wake |
| sleep_count | input | CNT_W | Consecutive still samples needed to sleep |
| dir_enable | input | 6 | Wake direction enables, R6 order |
| wake_en | input | 1 | Enables wake detection |
| sleep_en | input | 1 | Enables return-to-sleep detection |
| force_sleep | input | 1 | Strobe forcing the sleep state |
| release_flags | input | 1 | Strobe clearing flags and cause |
| awake | output | 1 | Current wake status |
| wake_flag | output | 1 | Latched wake event |
| sleep_flag | output | 1 | Latched return-to-sleep event |
| cause | output | 6 | Latched wake directions, R6 order |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The bench builds the engine with 8-bit samples, 6-bit thresholds and 4-bit counters. At these widths, every threshold setting of interest and every sign of change fit inside the sample range. The sweep covers thresholds 0, 1, 7, 31 and 63 on each of the three axes, in both directions, with changes one below, equal to and one above the threshold, so the strict comparison is tested at every boundary. The 4-bit counters keep the debounce runs short enough to test breaks in the middle of a run, release strobes that coincide with events, and force-sleep colliding with a sample.

// File: rtl/mwu_pkg.sv
package mwu_pkg;

    localparam int NUM_AXES = 3;
    localparam int NUM_DIRS = 2 * NUM_AXES;

    typedef enum logic {
        ST_ASLEEP = 1'b0,
        ST_AWAKE  = 1'b1
    } pwr_state_t;

    typedef struct packed {
        logic wake_pos;
        logic wake_neg;
        logic sleep_over;
    } axis_flags_t;

    typedef logic [NUM_DIRS-1:0] dir_vec_t;

endpackage

// File: rtl/mwu_axis_delta.sv
module mwu_axis_delta
    import mwu_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int THR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] sample,
    input  logic [THR_W-1:0]        wake_thr,
    input  logic [THR_W-1:0]        sleep_thr,
    output axis_flags_t             flags
);
    localparam int DW = SMP_W + 2;

    logic signed [SMP_W-1:0] prev_q;
    logic                    have_q;
    logic signed [DW-1:0]    diff;
    logic signed [DW-1:0]    ndiff;
    logic signed [DW-1:0]    wthr;
    logic signed [DW-1:0]    sthr;

    always_comb begin
        if (have_q) begin
            diff = $signed({{2{sample[SMP_W-1]}}, sample})
                 - $signed({{2{prev_q[SMP_W-1]}}, prev_q});
        end else begin
            diff = '0;
        end
        ndiff = -diff;
        wthr  = $signed({{(DW-THR_W){1'b0}}, wake_thr});
        sthr  = $signed({{(DW-THR_W){1'b0}}, sleep_thr});
        flags.wake_pos   = diff > wthr;
        flags.wake_neg   = ndiff > wthr;
        flags.sleep_over = (diff > sthr) || (ndiff > sthr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (smp_valid) begin
            prev_q <= sample;
            have_q <= 1'b1;
        end
    end

endmodule

// File: rtl/mwu_debounce.sv
module mwu_debounce #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             hit,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   next_cnt;
    logic [CNT_W:0]   lim_eff;

    always_comb begin
        lim_eff  = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
        next_cnt = {1'b0, cnt_q} + (CNT_W+1)'(1);
        fire     = step && hit && (next_cnt >= lim_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || fire) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= hit ? next_cnt[CNT_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/mwu_status.sv
module mwu_status
    import mwu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wake_fire,
    input  logic     sleep_fire,
    input  logic     force_sleep,
    input  logic     release_flags,
    input  dir_vec_t fire_dirs,
    output logic     awake,
    output logic     wake_flag,
    output logic     sleep_flag,
    output dir_vec_t cause
);
    pwr_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_ASLEEP;
            wake_flag  <= 1'b0;
            sleep_flag <= 1'b0;
            cause      <= '0;
        end else begin
            if (force_sleep) begin
                state_q <= ST_ASLEEP;
            end else if (wake_fire) begin
                state_q <= ST_AWAKE;
            end else if (sleep_fire) begin
                state_q <= ST_ASLEEP;
            end

            if (wake_fire) begin
                wake_flag <= 1'b1;
            end else if (release_flags) begin
                wake_flag <= 1'b0;
            end

            if (sleep_fire) begin
                sleep_flag <= 1'b1;
            end else if (release_flags) begin
                sleep_flag <= 1'b0;
            end

            if (release_flags) begin
                cause <= wake_fire ? fire_dirs : '0;
            end else if (wake_fire) begin
                cause <= cause | fire_dirs;
            end
        end
    end

    assign awake = (state_q == ST_AWAKE);

endmodule

// File: rtl/motion_wake_engine.sv
module motion_wake_engine
    import mwu_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int THR_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_x,
    input  logic signed [SMP_W-1:0] smp_y,
    input  logic signed [SMP_W-1:0] smp_z,
    input  logic [THR_W-1:0]        wake_thresh,
    input  logic [THR_W-1:0]        sleep_thresh,
    input  logic [CNT_W-1:0]        wake_count,
    input  logic [CNT_W-1:0]        sleep_count,
    input  logic [5:0]              dir_enable,
    input  logic                    wake_en,
    input  logic                    sleep_en,
    input  logic                    force_sleep,
    input  logic                    release_flags,
    output logic                    awake,
    output logic                    wake_flag,
    output logic                    sleep_flag,
    output logic [5:0]              cause,
    output logic                    irq
);
    logic signed [SMP_W-1:0] axis_smp [NUM_AXES];
    axis_flags_t             axis_fl  [NUM_AXES];
    dir_vec_t                raw_dirs;
    dir_vec_t                masked_dirs;
    logic [NUM_AXES-1:0]     over_sleep;
    logic                    wake_hit;
    logic                    still;
    logic                    wake_active;
    logic                    sleep_active;
    logic                    wake_fire;
    logic                    sleep_fire;

    assign axis_smp[0] = smp_x;
    assign axis_smp[1] = smp_y;
    assign axis_smp[2] = smp_z;

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        mwu_axis_delta #(
            .SMP_W(SMP_W),
            .THR_W(THR_W)
        ) u_delta (
            .clk      (clk),
            .rst      (rst),
            .smp_valid(smp_valid),
            .sample   (axis_smp[a]),
            .wake_thr (wake_thresh),
            .sleep_thr(sleep_thresh),
            .flags    (axis_fl[a])
        );
        assign raw_dirs[2*a]   = axis_fl[a].wake_pos;
        assign raw_dirs[2*a+1] = axis_fl[a].wake_neg;
        assign over_sleep[a]   = axis_fl[a].sleep_over;
    end

    assign masked_dirs  = raw_dirs & dir_enable;
    assign wake_hit     = |masked_dirs;
    assign still        = ~|over_sleep;
    assign wake_active  = wake_en && !awake;
    assign sleep_active = sleep_en && awake;

    mwu_debounce #(.CNT_W(CNT_W)) u_wake_cnt (
        .clk  (clk),
        .rst  (rst),
        .clear(force_sleep || !wake_active),
        .step (smp_valid && wake_active && !force_sleep),
        .hit  (wake_hit),
        .limit(wake_count),
        .fire (wake_fire)
    );

    mwu_debounce #(.CNT_W(CNT_W)) u_sleep_cnt (
        .clk  (clk),
        .rst  (rst),
        .clear(force_sleep || !sleep_active),
        .step (smp_valid && sleep_active && !force_sleep),
        .hit  (still),
        .limit(sleep_count),
        .fire (sleep_fire)
    );

    mwu_status u_status (
        .clk          (clk),
        .rst          (rst),
        .wake_fire    (wake_fire),
        .sleep_fire   (sleep_fire),
        .force_sleep  (force_sleep),
        .release_flags(release_flags),
        .fire_dirs    (masked_dirs),
        .awake        (awake),
        .wake_flag    (wake_flag),
        .sleep_flag   (sleep_flag),
        .cause        (cause)
    );

    assign irq = wake_flag || sleep_flag;

endmodule

// File: rtl/mwu_checker.sv
module mwu_checker (
    input logic       clk,
    input logic       rst,
    input logic       smp_valid,
    input logic       force_sleep,
    input logic       release_flags,
    input logic       awake,
    input logic       wake_flag,
    input logic       sleep_flag,
    input logic [5:0] cause,
    input logic       irq
);
    AST_WAKE_RAISES_AWAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> awake); // R4
    AST_AWAKE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(awake) |-> $past(smp_valid)); // R5
    AST_CAUSE_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        wake_flag |-> (cause != 6'd0)); // R7
    AST_SLEEP_DROPS_AWAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_flag) |-> !awake); // R8
    AST_FORCE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        force_sleep |=> !awake); // R10
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (release_flags && !smp_valid) |=> !irq); // R11
    AST_FLAG_FALL_BY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_flag) |-> $past(release_flags)); // R11
    AST_IDLE_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (cause == 6'd0)); // R12
endmodule

bind motion_wake_engine mwu_checker u_mwu_checker (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .force_sleep  (force_sleep),
    .release_flags(release_flags),
    .awake        (awake),
    .wake_flag    (wake_flag),
    .sleep_flag   (sleep_flag),
    .cause        (cause),
    .irq          (irq)
);

// File: tb/motion_wake_engine_test.sv
module motion_wake_engine_test;
    localparam int SW = 8;
    localparam int TW = 6;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic signed [SW-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [TW-1:0] wake_thresh = '0, sleep_thresh = '0;
    logic [CW-1:0] wake_count = '0, sleep_count = '0;
    logic [5:0] dir_enable = '0;
    logic wake_en = 1'b0, sleep_en = 1'b0, force_sleep = 1'b0, release_flags = 1'b0;
    logic awake, wake_flag, sleep_flag, irq;
    logic [5:0] cause;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench-side expectation
    int  mprev [3];
    bit  mhave = 0;
    bit  maw = 0, mwf = 0, msf = 0;
    bit [5:0] mcause = '0;
    int  wcnt = 0, scnt = 0;

    always #5 clk = ~clk;

    motion_wake_engine #(.SMP_W(SW), .THR_W(TW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .wake_thresh(wake_thresh), .sleep_thresh(sleep_thresh),
        .wake_count(wake_count), .sleep_count(sleep_count),
        .dir_enable(dir_enable), .wake_en(wake_en), .sleep_en(sleep_en),
        .force_sleep(force_sleep), .release_flags(release_flags),
        .awake(awake), .wake_flag(wake_flag), .sleep_flag(sleep_flag),
        .cause(cause), .irq(irq)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "awake", awake, maw);
        chk(tag, "wake_flag", wake_flag, mwf);
        chk(tag, "sleep_flag", sleep_flag, msf);
        chk(tag, "cause", cause, mcause);
        chk(tag, "irq", irq, mwf | msf);
    endtask

    function automatic int lim(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // one clock: drive at negedge, predict, check at next negedge
    task automatic cyc(bit v, int x, int y, int z, bit f, bit r, string tag);
        int s [3];
        bit [5:0] dirs;
        bit [5:0] m;
        bit quiet;
        s[0] = x; s[1] = y; s[2] = z;
        smp_valid = v; smp_x = x[SW-1:0]; smp_y = y[SW-1:0]; smp_z = z[SW-1:0];
        force_sleep = f; release_flags = r;

        if (!wake_en || maw) wcnt = 0;
        if (!sleep_en || !maw) scnt = 0;
        if (r) begin mwf = 0; msf = 0; mcause = '0; end
        dirs = '0; quiet = 1;
        if (v) begin
            for (int a = 0; a < 3; a++) begin
                int d;
                d = mhave ? s[a] - mprev[a] : 0;
                if (d > int'(wake_thresh))  dirs[2*a] = 1;
                if (-d > int'(wake_thresh)) dirs[2*a+1] = 1;
                if (d > int'(sleep_thresh) || -d > int'(sleep_thresh)) quiet = 0;
                mprev[a] = s[a];
            end
            mhave = 1;
        end
        m = dirs & dir_enable;
        if (f) begin
            maw = 0; wcnt = 0; scnt = 0;
        end else if (v) begin
            if (!maw) begin
                if (wake_en && m != 0) begin
                    if (wcnt + 1 >= lim(int'(wake_count))) begin
                        maw = 1; mwf = 1; mcause = mcause | m; wcnt = 0;
                    end else wcnt++;
                end else wcnt = 0;
            end else begin
                if (sleep_en && quiet) begin
                    if (scnt + 1 >= lim(int'(sleep_count))) begin
                        maw = 0; msf = 1; scnt = 0;
                    end else scnt++;
                end else scnt = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        smp_valid = 0; force_sleep = 0; release_flags = 0;
        compare(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    // clean sleep state with all three references at zero
    task automatic restart(string tag);
        cyc(1, 0, 0, 0, 1, 1, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int thr_list [5] = '{0, 1, 7, 31, 63};
        repeat (3) @(negedge clk);
        rst = 0;
        compare("R1");

        // R2: first sample is a zero change; later changes are relative
        wake_en = 1; dir_enable = 6'h3F; wake_thresh = 5; wake_count = 1;
        cyc(1, 100, -90, 50, 0, 0, "R2");
        cyc(1, 100, -90, 50, 0, 0, "R2");
        cyc(1, 105, -90, 50, 0, 0, "R2");
        cyc(1, 111, -90, 50, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 1, "R11");

        // R3: strict threshold sweep on every axis and sign
        foreach (thr_list[t]) begin
            wake_thresh = thr_list[t][TW-1:0];
            for (int a = 0; a < 3; a++) begin
                for (int sg = -1; sg <= 1; sg += 2) begin
                    for (int off = -1; off <= 1; off++) begin
                        int dl;
                        int v3 [3];
                        dl = thr_list[t] + off;
                        if (dl >= 0) begin
                            restart("R3");
                            v3 = '{0, 0, 0};
                            v3[a] = sg * dl;
                            cyc(1, v3[0], v3[1], v3[2], 0, 0, "R3");
                        end
                    end
                end
            end
        end

        // R4/R5: three consecutive moving samples; break resets
        restart("R4");
        wake_thresh = 4; wake_count = 3;
        cyc(1, 10, 0, 0, 0, 0, "R4");
        cyc(1, 20, 0, 0, 0, 0, "R4");
        cyc(1, 21, 0, 0, 0, 0, "R5");
        cyc(1, 31, 0, 0, 0, 0, "R5");
        idle(3, "R5");
        cyc(1, 41, 0, 0, 0, 0, "R5");
        cyc(1, 51, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 0, 0, 1, "R11");

        // R6: only +X enabled; -X and Y motion ignored
        restart("R6");
        dir_enable = 6'b000001; wake_count = 1;
        cyc(1, -20, 0, 0, 0, 0, "R6");
        cyc(1, -40, 30, 0, 0, 0, "R6");
        cyc(1, -40, 60, -30, 0, 0, "R6");
        cyc(1, -10, 90, -60, 0, 0, "R6");

        // R7/R11: combined cause; release keeps awake
        cyc(0, 0, 0, 0, 0, 1, "R11");
        restart("R7");
        dir_enable = 6'h3F;
        cyc(1, 20, 0, -20, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, 1, "R11");

        // R9: awake, back-to-sleep off: motion and stillness change nothing
        cyc(1, 60, 60, 60, 0, 0, "R9");
        cyc(1, 60, 60, 60, 0, 0, "R9");
        idle(2, "R9");

        // R10: force-sleep beats a moving sample in the same cycle
        cyc(1, 0, 0, 0, 1, 0, "R10");
        cyc(1, 40, 0, 0, 0, 0, "R10");

        // R8: still samples return to sleep; a jump resets the count
        sleep_en = 1; sleep_thresh = 3; sleep_count = 4;
        cyc(1, 42, 0, 0, 0, 0, "R8");
        cyc(1, 44, 0, 0, 0, 0, "R8");
        cyc(1, 47, 0, 0, 0, 0, "R8");
        cyc(1, 60, 0, 0, 0, 0, "R8");
        cyc(1, 63, 0, 0, 0, 0, "R8");
        cyc(1, 60, 2, 0, 0, 0, "R8");
        cyc(1, 60, 2, -3, 0, 0, "R8");
        cyc(1, 60, 2, -3, 0, 1, "R11");
        cyc(0, 0, 0, 0, 0, 1, "R12");

        // R9: after sleep, engine can wake again
        cyc(1, 90, 2, -3, 0, 0, "R9");
        cyc(1, 90, 2, -3, 0, 0, "R8");
        sleep_count = 0;
        cyc(1, 90, 2, -3, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 1, "R12");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule